// File: doc/BRIEF.md
# Dual-Channel PWM Current Chopper

This block regulates the current in the two windings of a stepper motor. It sits after the step-sequence translator. It takes the translator's four phase lines and two active-low inhibit lines, and produces the final gated drive signals. One chopping timebase serves both windings. Each tick re-arms a per-winding latch. When a winding's over-current comparator reports a trip, that winding's latch drops and its drive stays chopped until the next tick.

Chopping takes one of two forms, picked by a mode input. In inhibit mode the winding's inhibit line is pulled low, which gives fast decay. In phase mode the idle line of the winding's phase pair is raised while the active line keeps its level, which gives slow decay. The tick comes from an internal programmable divider, which also emits an active-low sync pulse. It can instead come from the falling edge of an external sync input, so that several controllers share one timebase. A reference-scale select lets the analog side drop the current limit to 70.7 % during two-phase-on half-step states, which evens out torque.

Top module: `dual_chopper`

## Requirements
- R1: A chop tick re-arms both winding latches; with no over-current present, a chopped winding returns to its unchopped drive at the tick.
- R2: An over-current input that is high for even one cycle drops that winding's latch, and the winding stays chopped after the input falls, until the next tick.
- R3: An over-current input that is high in the cycle of a tick keeps that winding's latch dropped.
- R4: With `chop_on_phase` low, a chopped winding has its inhibit output driven low while its phase outputs follow the translator.
- R5: With `chop_on_phase` high, a chopped winding has both of its phase lines driven high, provided one of them was high, while its inhibit output follows the translator.
- R6: Winding 1 is phase bits [3:2] (A = bit 3, B = bit 2) with `inh_in_n[0]`, `inh_out_n[0]` and `over_cur[0]`. Winding 2 is bits [1:0] (C = bit 1, D = bit 0) with index 1. The two windings chop independently.
- R7: When the translator already holds a winding's inhibit low, that winding's outputs follow the translator and no chopping is applied.
- R8: With `enable` low, all four phase outputs and both inhibit outputs are low one cycle later.
- R9: With `ext_sync_sel` low, a tick occurs every `tick_period`+1 clock cycles, or every DEF_PERIOD+1 cycles when `tick_period` is 0. `sync_out_n` is low for exactly one cycle per tick.
- R10: With `ext_sync_sel` high, the tick is the falling edge of `sync_in` after a two-stage capture, and `sync_out_n` is held high.
- R11: `ref_low` is 1 only when COMPENSATED is 1, `half_mode` is 1, and exactly two of the four phase inputs are high. Otherwise it is 0, so full-step operation stays at full scale.
- R12: During reset all phase and inhibit outputs are low, `ref_low` is 0 and `sync_out_n` is high. Both latches come out of reset armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Drive enable; low forces all outputs low |
| chop_on_phase | input | 1 | 1: chop by raising the idle phase line; 0: chop by inhibit |
| half_mode | input | 1 | 1: half-step sequencing in use |
| ph_in | input | 4 | Translator phase lines {A,B,C,D} |
| inh_in_n | input | 2 | Translator inhibit lines, active low |
| over_cur | input | 2 | Comparator trip per winding, high = over current |
| ext_sync_sel | input | 1 | 1: take the tick from sync_in |
| sync_in | input | 1 | External timebase, falling edge is the tick |
| tick_period | input | DIV_W | Internal divider period minus one; 0 selects the default |
| ph_out | output | 4 | Gated phase lines {A,B,C,D} |
| inh_out_n | output | 2 | Gated inhibit lines, active low |
| sync_out_n | output | 1 | One-cycle low pulse per internal tick |
| ref_low | output | 1 | 1 selects the 70.7 % current reference |

## Verification
The bench builds the block with DEF_PERIOD set to 19 and COMPENSATED set to 1. With these values the default divider period takes only 20 cycles to measure, and the reference-scale path is live. Most chop cases run with the external sync, so that ticks land in known cycles. The internal divider is then checked both with an explicit period of 9 and with the default, including the release of a chopped winding by an internal tick.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Number of lines in one winding's phase pair
    localparam int unsigned PAIR_LINES = 2;
    // Number of windings handled by the block
    localparam int unsigned NUM_PAIRS  = 2;
    localparam int unsigned NUM_PHASES = PAIR_LINES * NUM_PAIRS;

    // Registered state of one winding channel
    typedef struct packed {
        logic                  armed;   // latch set by tick, cleared by trip
        logic [PAIR_LINES-1:0] ph;      // gated phase pair
        logic                  inh_n;   // gated inhibit, active low
    } pair_st_t;

    // True when at least one line of the pair is energised
    function automatic logic pair_energised(input logic [PAIR_LINES-1:0] lines);
        return |lines;
    endfunction

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase #(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned DEF_PERIOD = 3332
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             sync_in,
    input  logic [DIV_W-1:0] tick_period,
    output logic             tick,
    output logic             sync_out_n
);

    localparam logic [DIV_W-1:0] DEF_P = DIV_W'(DEF_PERIOD);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             s1;
        logic             s2;
        logic             sync_n;
    } tb_st_t;

    tb_st_t st_q, st_d;
    logic [DIV_W-1:0] period;
    logic int_tick;
    logic ext_fall;

    always_comb begin
        st_d     = st_q;
        period   = (tick_period == '0) ? DEF_P : tick_period;
        int_tick = (st_q.cnt >= period);
        ext_fall = st_q.s2 & ~st_q.s1;

        st_d.cnt    = int_tick ? '0 : st_q.cnt + 1'b1;
        st_d.s1     = sync_in;
        st_d.s2     = st_q.s1;
        st_d.sync_n = ~(int_tick & ~ext_sel);

        tick = ext_sel ? ext_fall : int_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.s1     <= 1'b1;
            st_q.s2     <= 1'b1;
            st_q.sync_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out_n = st_q.sync_n;

endmodule

// File: rtl/chop_pair.sv
module chop_pair
    import chop_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  trip,
    input  logic                  enable,
    input  logic                  on_phase,
    input  logic [PAIR_LINES-1:0] ph_in,
    input  logic                  inh_in_n,
    output logic [PAIR_LINES-1:0] ph_out,
    output logic                  inh_out_n
);

    pair_st_t st_q, st_d;
    logic chopped;

    always_comb begin
        st_d = st_q;

        // Latch: set on tick unless tripped, held otherwise, cleared on trip
        st_d.armed = tick ? ~trip : (st_q.armed & ~trip);
        chopped    = ~st_d.armed;

        st_d.ph    = ph_in;
        st_d.inh_n = inh_in_n;

        if (!enable) begin
            st_d.ph    = '0;
            st_d.inh_n = 1'b0;
        end else if (inh_in_n && chopped) begin
            if (on_phase) begin
                if (pair_energised(ph_in)) begin
                    st_d.ph = '1;
                end
            end else begin
                st_d.inh_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.ph    <= '0;
            st_q.inh_n <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_out    = st_q.ph;
    assign inh_out_n = st_q.inh_n;

endmodule

// File: rtl/chop_ref_sel.sv
module chop_ref_sel
    import chop_pkg::*;
#(
    parameter bit COMPENSATED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   half_mode,
    input  logic [NUM_PHASES-1:0]  ph_in,
    output logic                   ref_low
);

    logic ref_q, ref_d;
    logic two_on;

    generate
        if (COMPENSATED) begin : g_comp
            always_comb two_on = ($countones(ph_in) == 2);
        end else begin : g_plain
            always_comb two_on = 1'b0;
        end
    endgenerate

    always_comb begin
        ref_d = half_mode & two_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_d;
    end

    assign ref_low = ref_q;

endmodule

// File: rtl/dual_chopper.sv
module dual_chopper
    import chop_pkg::*;
#(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned DEF_PERIOD  = 3332,
    parameter bit          COMPENSATED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             chop_on_phase,
    input  logic             half_mode,
    input  logic [3:0]       ph_in,
    input  logic [1:0]       inh_in_n,
    input  logic [1:0]       over_cur,
    input  logic             ext_sync_sel,
    input  logic             sync_in,
    input  logic [DIV_W-1:0] tick_period,
    output logic [3:0]       ph_out,
    output logic [1:0]       inh_out_n,
    output logic             sync_out_n,
    output logic             ref_low
);

    logic tick;

    chop_timebase #(
        .DIV_W      (DIV_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_sel     (ext_sync_sel),
        .sync_in     (sync_in),
        .tick_period (tick_period),
        .tick        (tick),
        .sync_out_n  (sync_out_n)
    );

    // Winding i uses phase bits [NUM_PHASES-1-PAIR_LINES*i -: PAIR_LINES]
    generate
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
            localparam int unsigned HI = NUM_PHASES - 1 - PAIR_LINES * i;
            chop_pair u_pair (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .trip      (over_cur[i]),
                .enable    (enable),
                .on_phase  (chop_on_phase),
                .ph_in     (ph_in[HI -: PAIR_LINES]),
                .inh_in_n  (inh_in_n[i]),
                .ph_out    (ph_out[HI -: PAIR_LINES]),
                .inh_out_n (inh_out_n[i])
            );
        end
    endgenerate

    chop_ref_sel #(
        .COMPENSATED (COMPENSATED)
    ) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_mode (half_mode),
        .ph_in     (ph_in),
        .ref_low   (ref_low)
    );

endmodule

// File: rtl/dual_chopper_chk.sv
module dual_chopper_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             chop_on_phase,
    input logic             half_mode,
    input logic [3:0]       ph_in,
    input logic [1:0]       inh_in_n,
    input logic [1:0]       over_cur,
    input logic             ext_sync_sel,
    input logic             sync_in,
    input logic [DIV_W-1:0] tick_period,
    input logic [3:0]       ph_out,
    input logic [1:0]       inh_out_n,
    input logic             sync_out_n,
    input logic             ref_low
);

    // R8: disabled drive forces every output low
    p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ph_out == 4'b0000) && (inh_out_n == 2'b00));

    // R9: internal sync pulse is one cycle wide
    p_sync_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_out_n && !ext_sync_sel) |=> sync_out_n);

    // R10: sync output idles high while following the external timebase
    p_ext_sync_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sync_sel |=> sync_out_n);

    // R11: full-step operation stays at full-scale reference
    p_ref_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !half_mode |=> !ref_low);

    // R7: translator inhibit passes straight through, no chopping
    p_trans_inh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !inh_in_n[0]) |=> (!inh_out_n[0] && ph_out[3:2] == $past(ph_in[3:2])));

    // R4: an over-current trip in inhibit mode pulls the inhibit low
    p_inh_chop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !chop_on_phase && inh_in_n[1] && over_cur[1]) |=> !inh_out_n[1]);

    // R5: an over-current trip in phase mode raises both lines of the pair
    p_idle_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && chop_on_phase && inh_in_n[0] && over_cur[0] && (|ph_in[3:2]))
        |=> (ph_out[3:2] == 2'b11) && inh_out_n[0]);

endmodule

bind dual_chopper dual_chopper_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/test_dual_chopper.sv
module test_dual_chopper;

    localparam int unsigned DIV_W = 16;
    localparam int unsigned DEF_P = 19;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b1;
    logic             chop_on_phase = 1'b0;
    logic             half_mode = 1'b1;
    logic [3:0]       ph_in = 4'b0101;
    logic [1:0]       inh_in_n = 2'b11;
    logic [1:0]       over_cur = 2'b00;
    logic             ext_sync_sel = 1'b1;
    logic             sync_in = 1'b1;
    logic [DIV_W-1:0] tick_period = '0;
    logic [3:0]       ph_out;
    logic [1:0]       inh_out_n;
    logic             sync_out_n;
    logic             ref_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dual_chopper #(
        .DIV_W       (DIV_W),
        .DEF_PERIOD  (DEF_P),
        .COMPENSATED (1'b1)
    ) i_dual_chopper (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .chop_on_phase (chop_on_phase),
        .half_mode     (half_mode),
        .ph_in         (ph_in),
        .inh_in_n      (inh_in_n),
        .over_cur      (over_cur),
        .ext_sync_sel  (ext_sync_sel),
        .sync_in       (sync_in),
        .tick_period   (tick_period),
        .ph_out        (ph_out),
        .inh_out_n     (inh_out_n),
        .sync_out_n    (sync_out_n),
        .ref_low       (ref_low)
    );

    // Vector: en, ctrl, half, ph[3:0], inh[1:0], oc[1:0], exp_ph[3:0], exp_inh[1:0], exp_ref
    typedef struct packed {
        logic       en;
        logic       ctrl;
        logic       half;
        logic [3:0] ph;
        logic [1:0] inh;
        logic [1:0] oc;
        logic [3:0] eph;
        logic [1:0] einh;
        logic       eref;
    } vec_t;

    localparam int NV = 11;
    localparam logic [17:0] VECS [0:NV-1] = '{
        {1'b1,1'b0,1'b1,4'b0101,2'b11,2'b00, 4'b0101,2'b11,1'b1}, // R1 R11 no trip
        {1'b1,1'b0,1'b1,4'b0101,2'b11,2'b01, 4'b0101,2'b10,1'b1}, // R2 R4 R6 winding 1
        {1'b1,1'b0,1'b1,4'b0101,2'b11,2'b10, 4'b0101,2'b01,1'b1}, // R4 R6 winding 2
        {1'b1,1'b1,1'b1,4'b0101,2'b11,2'b01, 4'b1101,2'b11,1'b1}, // R5 R6 winding 1
        {1'b1,1'b1,1'b1,4'b0101,2'b11,2'b11, 4'b1111,2'b11,1'b1}, // R5 both
        {1'b1,1'b1,1'b1,4'b1000,2'b01,2'b11, 4'b1100,2'b01,1'b0}, // R5 R7 R11 one-on
        {1'b1,1'b0,1'b1,4'b1000,2'b01,2'b11, 4'b1000,2'b00,1'b0}, // R4 R7
        {1'b0,1'b0,1'b1,4'b0101,2'b11,2'b00, 4'b0000,2'b00,1'b1}, // R8
        {1'b1,1'b0,1'b0,4'b0101,2'b11,2'b00, 4'b0101,2'b11,1'b0}, // R11 full step
        {1'b1,1'b1,1'b1,4'b1001,2'b11,2'b10, 4'b1011,2'b11,1'b1}, // R5 R6 winding 2
        {1'b1,1'b0,1'b1,4'b0010,2'b10,2'b01, 4'b0010,2'b10,1'b0}  // R7 no chop
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic ext_tick();
        @(negedge clk) sync_in = 1'b0;
        @(negedge clk) sync_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic trip_pulse(input logic [1:0] oc);
        @(negedge clk) over_cur = oc;
        @(negedge clk) over_cur = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    // Counts negedges between two consecutive low samples of sync_out_n
    task automatic measure_period(output int gap);
        int guard = 0;
        gap = 0;
        while (sync_out_n !== 1'b0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        do begin
            @(negedge clk);
            gap++;
        end while (sync_out_n !== 1'b0 && gap < 200);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int gap;
        vec_t v;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12 ph_out in reset", 32'(ph_out), 32'h0);
        chk("R12 inh_out_n in reset", 32'(inh_out_n), 32'h0);
        chk("R12 ref_low in reset", 32'(ref_low), 32'h0);
        chk("R12 sync_out_n in reset", 32'(sync_out_n), 32'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 latches armed after reset", {28'h0, ph_out, 2'b00, inh_out_n} , {28'h0, 4'b0101, 2'b00, 2'b11});

        // Vector walk, external timebase
        for (int i = 0; i < NV; i++) begin
            v = vec_t'(VECS[i]);
            @(negedge clk);
            enable        = v.en;
            chop_on_phase = v.ctrl;
            half_mode     = v.half;
            ph_in         = v.ph;
            inh_in_n      = v.inh;
            over_cur      = 2'b00;
            ext_tick();
            trip_pulse(v.oc);
            chk($sformatf("vector %0d ph_out (R2 R4 R5 R6 R7 R8)", i), 32'(ph_out), 32'(v.eph));
            chk($sformatf("vector %0d inh_out_n (R2 R4 R6 R7 R8)", i), 32'(inh_out_n), 32'(v.einh));
            chk($sformatf("vector %0d ref_low (R11)", i), 32'(ref_low), 32'(v.eref));
        end

        // R10: sync output held high in external mode
        chk("R10 sync_out_n high in external mode", 32'(sync_out_n), 32'h1);

        // R1: external tick re-arms a chopped winding
        @(negedge clk);
        enable = 1'b1; chop_on_phase = 1'b0; half_mode = 1'b1;
        ph_in = 4'b0101; inh_in_n = 2'b11;
        trip_pulse(2'b11);
        chk("R2 both windings chopped", 32'(inh_out_n), 32'h0);
        ext_tick();
        chk("R1 R10 sync falling edge re-arms both", 32'(inh_out_n), 32'h3);

        // R3: trip high during the tick keeps the latch dropped
        @(negedge clk) over_cur = 2'b01;
        @(negedge clk) sync_in = 1'b0;
        @(negedge clk) sync_in = 1'b1;
        repeat (2) @(negedge clk);
        over_cur = 2'b00;
        repeat (2) @(negedge clk);
        chk("R3 trip at tick keeps winding 1 chopped", 32'(inh_out_n), 32'h2);
        ext_tick();
        chk("R1 next clean tick releases winding 1", 32'(inh_out_n), 32'h3);

        // R9: internal divider with explicit period
        @(negedge clk);
        tick_period  = 16'd9;
        ext_sync_sel = 1'b0;
        measure_period(gap);
        measure_period(gap);
        chk("R9 internal period with tick_period=9", 32'(gap), 32'd10);
        @(negedge clk);
        chk("R9 sync pulse one cycle wide", 32'(sync_out_n), 32'h1);

        // R1: internal tick releases a chopped winding
        measure_period(gap);
        @(negedge clk) over_cur = 2'b10;
        @(negedge clk) over_cur = 2'b00;
        @(negedge clk);
        chk("R2 winding 2 chopped before internal tick", 32'(inh_out_n), 32'h1);
        repeat (10) @(negedge clk);
        chk("R1 internal tick releases winding 2", 32'(inh_out_n), 32'h3);

        // R9: default period when tick_period is zero
        @(negedge clk) tick_period = '0;
        measure_period(gap);
        measure_period(gap);
        chk("R9 default period", 32'(gap), 32'(DEF_P + 1));

        finish_run();
    end

endmodule